// File: doc/BRIEF.md
# Multi-Locality Ownership Arbiter

This block decides which of five software localities owns a shared trusted-module register interface. Every locality sees its own copy of one byte-wide access register. The copies sit in separate 4 KiB windows, and bits [14:12] of the byte address select the window. Each copy reports the same shared ownership state, seen from that locality's point of view: whether the interface is up, whether this locality owns it, and whether any other locality is waiting for it.

After reset the block holds its valid flag low for a fixed number of clock cycles. It ignores every write until that period ends. From then on:

- A locality asks for the interface by writing a request bit.
- If the interface is free, the request is granted at once.
- If another locality owns it, the request is recorded as pending.
- The owner gives the interface up by writing its active bit.
- On release, the highest-numbered pending locality takes over on the same clock edge.
- Every change of owner produces a one-cycle event for a neighbouring interrupt block.

Top module: `loc_arbiter`

## Requirements
- R1: Bit 7 (valid) of every access view reads 0 from reset until INIT_CYCLES rising edges have followed reset release, and reads 1 from then on. Writes sampled before valid is 1 have no effect. A new reset clears all ownership and pending state.
- R2: An access view is addressed only when byte address bits [11:0] are zero and bits [14:12] hold a locality number from 0 to 4. Any other address reads 0x00, and a write to it has no effect.
- R3: Bit 5 reads 1 only in the view of the locality that owns the interface. It reads 0 in all other views, and in every view when there is no owner.
- R4: A write with bit 1 set from a locality that does not own the interface, made while there is no owner, makes that locality the owner. Its view shows bit 5 set in the next cycle.
- R5: A write with bit 1 set from a non-owner while another locality owns the interface marks the writer as pending. Bit 2 of view L reads 1 when any locality other than L is pending.
- R6: A write with bit 5 set from the owner releases the interface. If any locality is pending, the highest-numbered pending locality becomes owner on the same edge and its pending mark clears. Otherwise the interface becomes free. When bits 5 and 1 are set together in an owner's write, the release applies.
- R7: Bit 5 written by a non-owner, and bit 1 written by the owner, change nothing.
- R8: loc_change_o is high for exactly one cycle after each edge where the owner changes: a grant to an idle interface, a handover, or a release to free. It is high in the same cycle the new state first reads back. It is low at all other times.
- R9: Bits 6, 4, 3 and 0 read 0, and writing 1 to bits 7, 6, 4, 3, 2 or 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Byte write strobe, sampled on the rising edge |
| addr_i | input | 15 | Byte address; [14:12] locality, [11:0] register offset |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Combinational read of the addressed access view |
| loc_change_o | output | 1 | One-cycle owner-change event |

## Verification
Two things can land on the same edge: the owner's release and the grant to the highest pending locality. The bench sets this up by queuing requests from localities 0 and 4 while locality 2 owns the interface, then releasing. One edge later it expects locality 4 to own the interface, locality 0 to still be pending, and one change pulse rather than two. A second collision is a single write that carries both request and release bits. The owner's copy must act as a release that hands over, while the other locality's copy must act as a request only. A behavioural model tracks owner, pending set and init count, and is compared with the read data and the change event on every clock.

// File: rtl/loc_arb_pkg.sv
package loc_arb_pkg;
  localparam int unsigned ADDR_W = 15;
  localparam int unsigned OFS_W  = 12;
  localparam int unsigned LOC_W  = ADDR_W - OFS_W;
  localparam int unsigned DW     = 8;

  localparam int unsigned B_VALID  = 7;
  localparam int unsigned B_ACTIVE = 5;
  localparam int unsigned B_PEND   = 2;
  localparam int unsigned B_REQ    = 1;

  typedef struct packed {
    logic             hit;
    logic [LOC_W-1:0] loc;
  } loc_sel_t;

  function automatic logic [DW-1:0] mk_view(input logic valid,
                                            input logic active,
                                            input logic others_pend);
    logic [DW-1:0] v;
    v           = '0;
    v[B_VALID]  = valid;
    v[B_ACTIVE] = valid & active;
    v[B_PEND]   = valid & others_pend;
    return v;
  endfunction
endpackage

// File: rtl/loc_decode.sv
module loc_decode
  import loc_arb_pkg::*;
#(
  parameter int unsigned NUM_LOC = 5
) (
  input  logic [ADDR_W-1:0] addr_i,
  output loc_sel_t          sel_o
);
  logic [LOC_W-1:0] loc_fld;
  logic             ofs_zero;
  logic             in_range;

  assign loc_fld   = addr_i[ADDR_W-1:OFS_W];
  assign ofs_zero  = (addr_i[OFS_W-1:0] == '0);
  assign in_range  = ({1'b0, loc_fld} < (LOC_W+1)'(NUM_LOC));
  assign sel_o.hit = ofs_zero & in_range;
  assign sel_o.loc = loc_fld;

  always_comb begin
    if (sel_o.hit) assert (sel_o.loc < LOC_W'(NUM_LOC)) else $error("p_hit_range_r2");
  end
endmodule

// File: rtl/loc_init_timer.sv
module loc_init_timer #(
  parameter int unsigned INIT_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic valid_o
);
  localparam int unsigned CNT_W = $clog2(INIT_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      valid_q <= 1'b0;
    end else if (!valid_q) begin
      cnt_q   <= cnt_q + 1'b1;
      valid_q <= (cnt_q == CNT_W'(INIT_CYCLES - 1));
    end
  end

  assign valid_o = valid_q;

  p_valid_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> valid_q);
  p_cnt_bound_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(INIT_CYCLES));
endmodule

// File: rtl/loc_owner_core.sv
module loc_owner_core
  import loc_arb_pkg::*;
#(
  parameter int unsigned NUM_LOC = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic               wr_i,
  input  logic [LOC_W-1:0]   loc_i,
  input  logic               req_i,
  input  logic               rel_i,
  output logic               owner_vld_o,
  output logic [LOC_W-1:0]   owner_o,
  output logic [NUM_LOC-1:0] pend_o,
  output logic               upd_o
);
  logic               owner_vld_q, owner_vld_d;
  logic [LOC_W-1:0]   owner_q, owner_d;
  logic [NUM_LOC-1:0] pend_q, pend_d;
  logic [NUM_LOC-1:0] wr_onehot;
  logic [LOC_W-1:0]   hi_loc;
  logic               is_owner, do_rel, do_req;

  assign wr_onehot = NUM_LOC'(1) << loc_i;
  assign is_owner  = owner_vld_q && (owner_q == loc_i);
  assign do_rel    = wr_i & valid_i & rel_i & is_owner;
  assign do_req    = wr_i & valid_i & req_i & ~is_owner;

  // highest-numbered pending locality wins
  always_comb begin
    hi_loc = '0;
    for (int i = 0; i < NUM_LOC; i++)
      if (pend_q[i]) hi_loc = LOC_W'(i);
  end

  always_comb begin
    owner_vld_d = owner_vld_q;
    owner_d     = owner_q;
    pend_d      = pend_q;
    if (do_rel) begin
      if (|pend_q) begin
        owner_d         = hi_loc;
        pend_d[hi_loc]  = 1'b0;
      end else begin
        owner_vld_d = 1'b0;
      end
    end else if (do_req) begin
      if (!owner_vld_q) begin
        owner_vld_d = 1'b1;
        owner_d     = loc_i;
      end else begin
        pend_d = pend_q | wr_onehot;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      owner_vld_q <= 1'b0;
      owner_q     <= '0;
      pend_q      <= '0;
    end else begin
      owner_vld_q <= owner_vld_d;
      owner_q     <= owner_d;
      pend_q      <= pend_d;
    end
  end

  assign owner_vld_o = owner_vld_q;
  assign owner_o     = owner_q;
  assign pend_o      = pend_q;
  assign upd_o       = do_rel | (do_req & ~owner_vld_q);

  p_no_state_before_valid_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> (!owner_vld_q && pend_q == '0));
  p_owner_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    owner_vld_q |-> (owner_q < LOC_W'(NUM_LOC)));
  p_grant_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && valid_i && req_i && !owner_vld_q) |=> (owner_vld_q && owner_q == $past(loc_i)));
  p_owner_not_pending_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    owner_vld_q |-> !pend_q[owner_q]);
  p_pend_needs_owner_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q != '0) |-> owner_vld_q);
  p_release_free_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && valid_i && rel_i && is_owner && pend_q == '0) |=> !owner_vld_q);
  p_handover_count_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && valid_i && rel_i && is_owner && pend_q != '0)
      |=> (owner_vld_q && $countones(pend_q) == $countones($past(pend_q)) - 1));
  p_stray_release_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !req_i && !is_owner) |=> $stable(owner_q) && $stable(owner_vld_q));
endmodule

// File: rtl/loc_arbiter.sv
module loc_arbiter
  import loc_arb_pkg::*;
#(
  parameter int unsigned NUM_LOC     = 5,
  parameter int unsigned INIT_CYCLES = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic              loc_change_o
);
  localparam int unsigned NUM_SLOT = 1 << LOC_W;

  loc_sel_t           sel;
  logic               valid;
  logic               owner_vld;
  logic [LOC_W-1:0]   owner;
  logic [NUM_LOC-1:0] pend;
  logic               upd;
  logic               chg_q;
  logic [DW-1:0]      view [NUM_SLOT];
  logic               unused_wdata;

  assign unused_wdata = ^wdata_i;

  loc_decode #(.NUM_LOC(NUM_LOC)) u_dec (
    .addr_i (addr_i),
    .sel_o  (sel)
  );

  loc_init_timer #(.INIT_CYCLES(INIT_CYCLES)) u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_o (valid)
  );

  loc_owner_core #(.NUM_LOC(NUM_LOC)) u_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .valid_i     (valid),
    .wr_i        (wr_en_i & sel.hit),
    .loc_i       (sel.loc),
    .req_i       (wdata_i[B_REQ]),
    .rel_i       (wdata_i[B_ACTIVE]),
    .owner_vld_o (owner_vld),
    .owner_o     (owner),
    .pend_o      (pend),
    .upd_o       (upd)
  );

  for (genvar g = 0; g < NUM_SLOT; g++) begin : g_view
    if (g < NUM_LOC) begin : g_live
      logic [NUM_LOC-1:0] others;
      assign others  = pend & ~(NUM_LOC'(1) << g);
      assign view[g] = mk_view(valid, owner_vld && (owner == LOC_W'(g)), |others);
    end else begin : g_hole
      assign view[g] = '0;
    end
  end

  assign rdata_o = sel.hit ? view[sel.loc] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chg_q <= 1'b0;
    else         chg_q <= upd;
  end

  assign loc_change_o = chg_q;

  p_change_tracks_owner_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((owner_vld != $past(owner_vld)) || (owner_vld && owner != $past(owner))) |-> chg_q);
  p_change_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_q && $past(owner_vld) == owner_vld && owner == $past(owner) |-> 1'b0);
  p_onehot_active_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({view[4][B_ACTIVE], view[3][B_ACTIVE], view[2][B_ACTIVE],
              view[1][B_ACTIVE], view[0][B_ACTIVE]}));
  p_quiet_bits_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o & 8'h59) == 8'h00);
endmodule

// File: tb/sim_loc_arbiter.sv
`timescale 1ns/1ps
module sim_loc_arbiter;
  localparam int INIT = 16;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en = 1'b0;
  logic [14:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        chg;

  int checks = 0;
  int errors = 0;

  // behavioural reference
  int       m_owner = -1;
  bit [4:0] m_pend = '0;
  int       m_cnt = 0;
  bit       m_chg = 1'b0;

  always #4 clk = ~clk;

  loc_arbiter #(.NUM_LOC(5), .INIT_CYCLES(INIT)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .loc_change_o(chg)
  );

  function automatic bit hit(input logic [14:0] a);
    return (a[11:0] == 12'h000) && (a[14:12] < 3'd5);
  endfunction

  function automatic logic [7:0] exp_rd(input logic [14:0] a);
    logic [7:0] v;
    int l;
    if (m_cnt < INIT || !hit(a)) return 8'h00;
    l = int'(a[14:12]);
    v = 8'h80;
    if (m_owner == l) v[5] = 1'b1;
    for (int i = 0; i < 5; i++) if (i != l && m_pend[i]) v[2] = 1'b1;
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rst_ni) begin
      m_owner = -1; m_pend = '0; m_cnt = 0; m_chg = 1'b0;
    end else begin
      m_chg = 1'b0;
      if (wr_en && hit(addr) && m_cnt >= INIT) begin
        int l;
        l = int'(addr[14:12]);
        if (wdata[5] && m_owner == l) begin
          if (m_pend != 0) begin
            int h;
            h = 0;
            for (int i = 0; i < 5; i++) if (m_pend[i]) h = i;
            m_owner = h; m_pend[h] = 1'b0;
          end else m_owner = -1;
          m_chg = 1'b1;
        end else if (wdata[1] && m_owner != l) begin
          if (m_owner < 0) begin m_owner = l; m_chg = 1'b1; end
          else m_pend[l] = 1'b1;
        end
      end
      if (m_cnt < INIT) m_cnt++;
    end
  end

  // every-clock comparison against the model
  always @(negedge clk) begin
    if (rst_ni) begin
      checks++;
      if (rdata !== exp_rd(addr)) begin
        errors++;
        $display("FAIL R3 model read addr=%h actual=%h expected=%h", addr, rdata, exp_rd(addr));
      end
      checks++;
      if (chg !== m_chg) begin
        errors++;
        $display("FAIL R8 model change actual=%b expected=%b", chg, m_chg);
      end
    end
  end

  task automatic drive(input logic w, input logic [14:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    wr_en = w; addr = a; wdata = d;
  endtask

  task automatic look(input logic [14:0] a, input logic [7:0] exp, input string tag);
    drive(1'b0, a, 8'h00);
    @(negedge clk);
    checks++;
    if (rdata !== exp) begin
      errors++;
      $display("FAIL %s read addr=%h actual=%h expected=%h", tag, a, rdata, exp);
    end
  endtask

  task automatic wr(input logic [14:0] a, input logic [7:0] d, input logic exp_chg, input string tag);
    drive(1'b1, a, d);
    drive(1'b0, a, 8'h00);
    @(negedge clk);
    checks++;
    if (chg !== exp_chg) begin
      errors++;
      $display("FAIL %s change after write %h actual=%b expected=%b", tag, d, chg, exp_chg);
    end
  endtask

  function automatic logic [14:0] la(input int l);
    return {3'(l), 12'h000};
  endfunction

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    // R1: not valid yet, writes ignored
    look(la(0), 8'h00, "R1");
    wr(la(0), 8'h02, 1'b0, "R1");
    look(la(4), 8'h00, "R1");
    repeat (INIT) drive(1'b0, la(0), 8'h00);
    look(la(0), 8'h80, "R1");
    look(la(4), 8'h80, "R1");
    // R4 grant to idle interface
    wr(la(2), 8'h02, 1'b1, "R8");
    look(la(2), 8'ha0, "R4");
    look(la(0), 8'h80, "R3");
    // R5 pending
    wr(la(0), 8'h02, 1'b0, "R5");
    look(la(2), 8'ha4, "R5");
    look(la(0), 8'h80, "R5");
    wr(la(4), 8'h02, 1'b0, "R5");
    look(la(0), 8'h84, "R5");
    // R7 stray release, owner re-request
    wr(la(4), 8'h20, 1'b0, "R7");
    look(la(2), 8'ha4, "R7");
    wr(la(2), 8'h02, 1'b0, "R7");
    look(la(2), 8'ha4, "R7");
    // R2 bad offsets and localities
    wr({3'd2, 12'h004}, 8'h20, 1'b0, "R2");
    look(la(2), 8'ha4, "R2");
    look({3'd2, 12'h008}, 8'h00, "R2");
    look(la(5), 8'h00, "R2");
    wr(la(6), 8'h02, 1'b0, "R2");
    look(la(7), 8'h00, "R2");
    // R9 other bits
    wr(la(2), 8'hdd, 1'b0, "R9");
    look(la(2), 8'ha4, "R9");
    look(la(1), 8'h84, "R9");
    // R6 handover to highest pending
    wr(la(2), 8'h20, 1'b1, "R6");
    look(la(4), 8'ha4, "R6");
    look(la(2), 8'h84, "R6");
    // combined bits: owner release wins
    wr(la(4), 8'h22, 1'b1, "R6");
    look(la(0), 8'ha0, "R6");
    // combined bits from a non-owner act as request
    wr(la(3), 8'h22, 1'b0, "R7");
    look(la(0), 8'ha4, "R5");
    wr(la(0), 8'h20, 1'b1, "R6");
    look(la(3), 8'ha0, "R6");
    wr(la(3), 8'h20, 1'b1, "R8");
    look(la(3), 8'h80, "R6");
    wr(la(1), 8'h02, 1'b1, "R4");
    look(la(1), 8'ha0, "R4");
    // R1 reset clears
    drive(1'b0, la(1), 8'h00);
    rst_ni = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_ni = 1'b1;
    look(la(1), 8'h00, "R1");
    repeat (INIT) drive(1'b0, la(1), 8'h00);
    look(la(1), 8'h80, "R1");
    drive(1'b0, la(0), 8'h00);
    finish_run();
  end
endmodule